// File: doc/BRIEF.md
# Serial-in latched output driver logic

This block is the digital core of a ten-channel driver with a serial input. A bit stream on `ser_in` enters a shift register on each rising edge of `clk`. The bit that has moved all the way through the register leaves on `ser_out`, so several devices can be chained to share one data line.

A bank of level-sensitive latches sits behind the register. While `strobe` is high the latches are transparent and follow the register. When `strobe` goes low they keep the value they last held. The `blank` input forces every channel enable low and leaves the latch contents unchanged, so a channel that was on before blanking comes back on once `blank` falls.

Top module: `shift_latch_driver`

## Requirements
- R1: On each rising edge of `clk`, the value of `ser_in` is captured into register stage 0. Stage 0 is the stage nearest the serial input.
- R2: On each rising edge, every stage i takes the value of stage i-1. `ser_out` always equals stage 9, so a bit appears on `ser_out` after ten clocks. Register stage i controls `chan_on[i]`.
- R3: While `strobe` is high, each latch follows its register stage. The latch tracks each new value through successive shifts for as long as `strobe` stays high.
- R4: While `strobe` is low, the latches hold their value no matter how much shifting takes place. With `blank` low, `chan_on` does not change.
- R5: While `blank` is high, all ten bits of `chan_on` are 0 (channel off).
- R6: `blank` does not alter the latches. When `blank` returns low, each `chan_on[i]` again shows latch i, the same value it had before blanking.
- R7: While `rst_n` is low, the register and the latches are cleared to zero at once, without waiting for a clock. `chan_on` and `ser_out` are then 0.
- R8: With `strobe` held high, so that the latches are bypassed, and `blank` held high during loading, `chan_on` stays 0 while data shifts. When `blank` falls, `chan_on` shows the register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; data is captured on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data input |
| strobe | input | 1 | Latch enable; the latches are transparent while it is high |
| blank | input | 1 | Forces all channel enables off while it is high |
| chan_on | output | 10 | Channel enables; 1 = channel on |
| ser_out | output | 1 | Last register stage, used for cascading |

## Verification
The clocked properties sample `strobe`, `blank` and `ser_in` at the rising clock edge. They therefore assume that these inputs change only away from that edge, and that `strobe` does not pulse between two edges without being seen. The bench meets this by changing every input on the falling edge only, so each level lasts one full clock period. The shift and cascade properties also assume that reset was inactive at the previous edge, and they are written with that guard.

// File: rtl/shift_latch_driver.sv
module shift_latch_driver #(
  parameter int CHANNELS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_in,
  input  logic                strobe,
  input  logic                blank,
  output logic [CHANNELS-1:0] chan_on,
  output logic                ser_out
);

  localparam int TOP = CHANNELS - 1;

  logic [CHANNELS-1:0] stage_q;
  logic [CHANNELS-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[TOP-1:0], ser_in};
  end

  always_latch begin
    if (!rst_n)      latch_q = '0;
    else if (strobe) latch_q = stage_q;
  end

  assign ser_out = stage_q[TOP];
  assign chan_on = blank ? '0 : latch_q;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stage_q[0] == $past(ser_in)); // R1

  AST_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ser_out == $past(stage_q[TOP-1])); // R2

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> latch_q == stage_q); // R3

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && $past(!strobe) && $past(rst_n)) |-> $stable(latch_q)); // R4

  AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> $countones(chan_on) == 0); // R5

  AST_UNBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blank) && !strobe && $past(!strobe) && $past(rst_n)) |-> chan_on == $past(latch_q)); // R6

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (chan_on == '0 && !ser_out); // R7
  end

endmodule

// File: tb/shift_latch_driver_tb_top.sv
module shift_latch_driver_tb_top;
  localparam int N = 10;

  logic clk = 0, rst_n = 0, ser_in = 0, strobe = 0, blank = 0;
  logic [N-1:0] chan_on;
  logic ser_out;

  shift_latch_driver #(.CHANNELS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe),
    .blank(blank), .chan_on(chan_on), .ser_out(ser_out)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [N-1:0] chan;
    logic         sout;
    string        req;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0;
  logic [N-1:0] m_stage = '0, m_latch = '0;

  task automatic compare(input item_t it);
    checks++;
    if (chan_on !== it.chan || ser_out !== it.sout) begin
      errors++;
      $display("FAIL %s: chan_on=%b ser_out=%b expected chan_on=%b ser_out=%b",
               it.req, chan_on, ser_out, it.chan, it.sout);
    end
  endtask

  task automatic cycle(input logic r, input logic d, input logic s,
                       input logic b, input string req);
    item_t it;
    @(negedge clk);
    rst_n = r; ser_in = d; strobe = s; blank = b;
    if (!r) begin
      m_stage = '0; m_latch = '0;
    end else begin
      m_stage = {m_stage[N-2:0], d};
      if (s) m_latch = m_stage;
    end
    it.chan = b ? '0 : m_latch;
    it.sout = m_stage[N-1];
    it.req  = req;
    exp_q.push_back(it);
  endtask

  task automatic load(input logic [N-1:0] word, input logic s, input logic b,
                      input string req);
    for (int i = N - 1; i >= 0; i--) cycle(1, word[i], s, b, req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    item_t it;
    #3;
    it.chan = '0; it.sout = 0; it.req = "R7 reset state";
    compare(it);
    cycle(0, 1, 1, 0, "R7 in reset");
    cycle(1, 1, 0, 0, "R1");
    // R4: shift a word with strobe low; outputs must stay put
    load(10'b1011001110, 0, 0, "R4 hold while shifting");
    // R3: single strobe cycle loads the latch
    cycle(1, 0, 1, 0, "R3 strobe pulse");
    load(10'b0101010101, 0, 0, "R4 hold after pulse");
    // R2: cascade observes first bits on ser_out
    for (int i = 0; i < N; i++) cycle(1, i[0], 0, 0, "R2 cascade");
    // R3: strobe high across many shifts
    load(10'b1110000111, 1, 0, "R3 transparent follow");
    cycle(1, 1, 0, 0, "R4 freeze");
    // R5 / R6: blank while latched, with shifting below
    load(10'b0011110000, 0, 1, "R5 blanked");
    cycle(1, 0, 0, 0, "R6 unblank restores");
    cycle(1, 1, 0, 1, "R5 reblank");
    cycle(1, 1, 0, 0, "R6 unblank again");
    // R8: bypass mode, blank during loading
    load(10'b1100101011, 1, 1, "R8 bypass load blanked");
    cycle(1, 0, 1, 0, "R8 bypass release");
    cycle(1, 1, 1, 0, "R8 bypass follow");
    // R7: asynchronous reset in mid-run
    cycle(0, 1, 1, 0, "R7 midrun reset");
    cycle(1, 1, 1, 0, "R1 after reset");
    load(10'b1000000001, 0, 0, "R2 walk");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule